// File: doc/BRIEF.md
# Streaming Roman Numeral Decoder

This block turns a Roman numeral, delivered one ASCII byte per transfer over a valid/ready stream, into a signed binary integer. A zero byte closes each numeral. The block keeps the most recent symbol waiting in a register. It settles that symbol's sign only when the following byte arrives. A waiting symbol whose value is below the value of the next symbol is subtracted, and in every other case it is added. The terminator counts as value zero, so the final symbol is always added.

When the terminator is accepted, the block shows the total for a single cycle together with a done strobe. An error flag goes out with the total if any byte in the numeral was not one of the seven uppercase symbols. The block then clears its total and its error state and waits for the next numeral. It does not check canonical form, so inputs such as IIII or VV are simply summed by the same rule.

Top module: `roman_stream_dec`

## Requirements
- R1: The uppercase symbols decode as I (0x49) = 1, V (0x56) = 5, X (0x58) = 10, L (0x4C) = 50, C (0x43) = 100, D (0x44) = 500, M (0x4D) = 1000. A numeral made of one symbol yields that symbol's value.
- R2: A symbol whose value is strictly smaller than the value of the next accepted symbol is subtracted from the total (IV = 4, MCMXCIV = 1994).
- R3: A symbol whose value is equal to or greater than the value of the next symbol is added. The last symbol before the terminator is always added (LVIII = 58).
- R4: A terminator (0x00) that arrives with no symbols before it gives a total of 0 and no error.
- R5: Any byte that is neither one of the seven symbols nor 0x00 sets an error, and that error is reported with done. The byte adds nothing to the total and does not break the comparison between the symbols on either side of it.
- R6: outDone is high for exactly one cycle for each terminator. While outDone is low, outSum and outErr are 0.
- R7: outDone, outSum and outErr appear in the cycle right after the clock edge that accepts the terminator. inReady is low during that cycle and high in every other cycle after reset.
- R8: After done, the total and the error are cleared. The next numeral is decoded without any influence from the previous one.
- R9: The total is kept as a 16-bit two's complement value and wraps modulo 65536 (seventy M symbols give 4464).
- R10: A byte presented while inValid is low has no effect. This includes a zero byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input byte is present |
| inReady | output | 1 | Block can accept a byte |
| inByte | input | 8 | ASCII character, or 0x00 as terminator |
| outDone | output | 1 | One-cycle strobe marking a completed numeral |
| outSum | output | 16 | Signed total, valid while outDone is high |
| outErr | output | 1 | At least one illegal byte was seen in the numeral |

## Verification
Errors inside the block can only be seen at its outputs through the done cycle, one edge after the terminator is accepted. There are a few ways a fault shows up. A pending symbol that is lost or left stale makes the total wrong by that symbol's value, with a subtract-versus-add mix-up costing twice that value. An error flag that is not cleared shows up as a false error on the next clean numeral, and a total that is not cleared shows up as an offset on the next numeral. For this reason each numeral is compared with an independent model, and clean numerals are run directly after erroneous ones and after very long ones.

// File: rtl/roman_pkg.sv
package roman_pkg;

  localparam int VAL_W = 11;

  typedef struct packed {
    logic pendLoad;  // capture incoming symbol as the pending one
    logic commit;    // fold pending symbol into the total
    logic setErr;    // illegal byte seen
    logic finish;    // terminator: publish result and clear
  } strobes_t;

  function automatic logic [VAL_W-1:0] symVal(input logic [7:0] ch);
    case (ch)
      8'h49:   symVal = VAL_W'(1);
      8'h56:   symVal = VAL_W'(5);
      8'h58:   symVal = VAL_W'(10);
      8'h4C:   symVal = VAL_W'(50);
      8'h43:   symVal = VAL_W'(100);
      8'h44:   symVal = VAL_W'(500);
      8'h4D:   symVal = VAL_W'(1000);
      default: symVal = '0;
    endcase
  endfunction

endpackage

// File: rtl/roman_ctrl.sv
module roman_ctrl
  import roman_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     isTerm,
  input  logic     isLegal,
  output logic     inReady,
  output strobes_t strb
);

  typedef enum logic [1:0] {ST_EMPTY, ST_HELD, ST_DONE} state_t;
  state_t state, stateNext;

  logic accept;

  assign inReady = (state != ST_DONE);
  assign accept  = inValid && inReady;

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      ST_EMPTY: if (accept) begin
        if (isTerm) begin
          strb.finish = 1'b1;
          stateNext   = ST_DONE;
        end else if (isLegal) begin
          strb.pendLoad = 1'b1;
          stateNext     = ST_HELD;
        end else begin
          strb.setErr = 1'b1;
        end
      end
      ST_HELD: if (accept) begin
        if (isTerm) begin
          strb.commit = 1'b1;
          strb.finish = 1'b1;
          stateNext   = ST_DONE;
        end else if (isLegal) begin
          strb.commit   = 1'b1;
          strb.pendLoad = 1'b1;
        end else begin
          strb.setErr = 1'b1;
        end
      end
      default: stateNext = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_EMPTY;
    else       state <= stateNext;
  end

  // R7
  term_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && isTerm) |=> !inReady);

  // R7
  ready_returns_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |=> inReady);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> (strb == '0));

endmodule

// File: rtl/roman_dpath.sv
module roman_dpath
  import roman_pkg::*;
#(
  parameter int SUM_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [7:0]              inByte,
  input  strobes_t                strb,
  output logic                    isTerm,
  output logic                    isLegal,
  output logic                    outDone,
  output logic signed [SUM_W-1:0] outSum,
  output logic                    outErr
);

  localparam int PAD_W = SUM_W - VAL_W;

  logic [VAL_W-1:0]        inVal, pendVal;
  logic signed [SUM_W-1:0] accReg, pendExt, delta, accNext;
  logic                    errReg, errNext;

  assign inVal   = symVal(inByte);
  assign isTerm  = (inByte == 8'h00);
  assign isLegal = (inVal != '0);

  assign pendExt = {{PAD_W{1'b0}}, pendVal};
  assign delta   = (pendVal < inVal) ? -pendExt : pendExt;
  assign accNext = strb.commit ? accReg + delta : accReg;
  assign errNext = errReg | strb.setErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg  <= '0;
      pendVal <= '0;
      errReg  <= 1'b0;
      outDone <= 1'b0;
      outSum  <= '0;
      outErr  <= 1'b0;
    end else begin
      if (strb.pendLoad) pendVal <= inVal;
      if (strb.finish) begin
        outDone <= 1'b1;
        outSum  <= accNext;
        outErr  <= errNext;
        accReg  <= '0;
        errReg  <= 1'b0;
      end else begin
        outDone <= 1'b0;
        outSum  <= '0;
        outErr  <= 1'b0;
        accReg  <= accNext;
        errReg  <= errNext;
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outDone |=> !outDone);

  // R6
  quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outDone |-> (outSum == '0 && !outErr));

  // R5
  err_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setErr && !strb.finish) |=> (errReg || outDone));

  // R8
  fresh_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    outDone |-> (accReg == '0 && !errReg));

endmodule

// File: rtl/roman_stream_dec.sv
module roman_stream_dec
  import roman_pkg::*;
#(
  parameter int SUM_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [7:0]              inByte,
  output logic                    outDone,
  output logic signed [SUM_W-1:0] outSum,
  output logic                    outErr
);

  strobes_t strb;
  logic     isTerm, isLegal;

  roman_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .isTerm  (isTerm),
    .isLegal (isLegal),
    .inReady (inReady),
    .strb    (strb)
  );

  roman_dpath #(.SUM_W(SUM_W)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .inByte  (inByte),
    .strb    (strb),
    .isTerm  (isTerm),
    .isLegal (isLegal),
    .outDone (outDone),
    .outSum  (outSum),
    .outErr  (outErr)
  );

endmodule

// File: tb/roman_stream_dec_tb.sv
module roman_stream_dec_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  inByte = 8'h00;
  logic        outDone;
  logic [15:0] outSum;
  logic        outErr;

  int checks = 0;
  int failures = 0;

  logic [7:0] str [0:79];
  int         len;
  logic [7:0] syms [0:6] = '{8'h49, 8'h56, 8'h58, 8'h4C, 8'h43, 8'h44, 8'h4D};

  always #10 clk = ~clk;

  roman_stream_dec dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inByte(inByte), .outDone(outDone), .outSum(outSum), .outErr(outErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int refVal(input logic [7:0] c);
    case (c)
      "I": return 1;    "V": return 5;   "X": return 10;
      "L": return 50;   "C": return 100; "D": return 500;
      "M": return 1000;
      default: return 0;
    endcase
  endfunction

  function automatic int expSum(input int n);
    int s = 0;
    int prev = -1;
    for (int i = 0; i < n; i++) begin
      int v = refVal(str[i]);
      if (v != 0) begin
        if (prev >= 0) s += (prev < v) ? -prev : prev;
        prev = v;
      end
    end
    if (prev >= 0) s += prev;
    return int'(s[15:0]);
  endfunction

  function automatic int expErr(input int n);
    for (int i = 0; i < n; i++)
      if (refVal(str[i]) == 0) return 1;
    return 0;
  endfunction

  // called at a negedge; returns at the negedge after acceptance
  task automatic putByte(input logic [7:0] b);
    while (!inReady) @(negedge clk);
    inValid = 1'b1;
    inByte  = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic idleGap(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      inByte = ($urandom % 2) ? 8'h00 : 8'h49;  // R10: garbage with valid low
      @(negedge clk);
      chk({req, " R10 no done while idle"}, outDone, 0);
    end
  endtask

  task automatic runStr(input string req, input int maxGap);
    int es = expSum(len);
    int ee = expErr(len);
    for (int i = 0; i < len; i++) begin
      putByte(str[i]);
      if (maxGap > 0) idleGap($urandom % (maxGap + 1), req);
    end
    putByte(8'h00);
    chk({req, " R7 done"}, outDone, 1);
    chk({req, " sum"}, int'(outSum), es);
    chk({req, " R5 err"}, outErr, ee);
    chk({req, " R7 ready low"}, inReady, 0);
    @(negedge clk);
    chk({req, " R6 done drops"}, outDone, 0);
    chk({req, " R6 sum quiet"}, int'(outSum), 0);
    chk({req, " R7 ready back"}, inReady, 1);
  endtask

  task automatic setStr(input string s);
    len = s.len();
    for (int i = 0; i < len; i++) str[i] = s[i];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("reset outDone", outDone, 0);
    chk("reset outSum", int'(outSum), 0);
    chk("reset outErr", outErr, 0);
    chk("reset inReady", inReady, 1);

    // R1 single symbols
    foreach (syms[k]) begin
      len = 1; str[0] = syms[k];
      runStr("R1 single", 0);
    end
    // R2 subtractive pairs and mixes
    setStr("IV");      runStr("R2 IV", 0);
    setStr("IX");      runStr("R2 IX", 0);
    setStr("XL");      runStr("R2 XL", 0);
    setStr("XC");      runStr("R2 XC", 0);
    setStr("CD");      runStr("R2 CD", 0);
    setStr("CM");      runStr("R2 CM", 0);
    setStr("MCMXCIV"); runStr("R2 MCMXCIV", 0);
    // R3 additive
    setStr("III");     runStr("R3 III", 0);
    setStr("LVIII");   runStr("R3 LVIII", 2);
    setStr("VV");      runStr("R3 VV", 0);
    // R4 empty numeral
    len = 0;           runStr("R4 empty", 0);
    // R5 illegal bytes, then R8 clean numeral after
    setStr("IaX");     runStr("R5 IaX", 0);
    setStr("V");       runStr("R8 after err", 0);
    len = 2; str[0] = 8'hFF; str[1] = "M";
    runStr("R5 high byte", 0);
    // R9 wrap
    len = 70;
    for (int i = 0; i < 70; i++) str[i] = "M";
    runStr("R9 wrap", 0);
    setStr("XIV");     runStr("R8 after wrap", 0);
    // R10 stalls with idle garbage
    setStr("CXLIX");   runStr("R10 stalled", 3);

    // random mix
    for (int t = 0; t < 60; t++) begin
      len = 1 + ($urandom % 12);
      for (int i = 0; i < len; i++) begin
        if (($urandom % 16) == 0) str[i] = 8'h80 | 8'($urandom % 128);
        else                      str[i] = syms[$urandom % 7];
      end
      runStr("R2 R3 R5 random", ($urandom % 2) ? 2 : 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule